// File: doc/BRIEF.md
# High-Side Current-Limit Calibration and Trip Controller

This block controls the overcurrent protection of a synchronous buck power stage. It has two duties. After a calibration request it finds a 6-bit current-limit threshold. It does this by ramping a DAC code upward one step at a time. An external comparator reports when the DAC voltage has passed the set voltage, and the block then freezes the code. If the ramp reaches full scale without a comparator response, current limiting is switched off for that calibration. While soft-start runs, the code sent to the DAC is doubled and clipped to full scale. Codes small enough to mean an effective limit of zero are sent as zero.

During switching, the block counts the length of every high-side pulse in clock ticks. It keeps three quarters of the last completed count as a sampling window for the next pulse. A trip is declared only when the sense comparator is high inside that window. After a trip, the pulse in progress runs to its end. The block then lets the next pulse run for half of the previous on-time, turns both switches off for four soft-start durations, and finally issues a one-cycle retry request.

Top module: `ilim_trip_ctrl`

## Requirements
- R1: A `cal_req` pulse clears the code to 0. Every STEP_CYC cycles the synchronised calibration comparator is sampled. If it is high, the code freezes and `cal_done` rises. If it is low, the code rises by one. With STEP_CYC=4 and a comparator that reads high at code t, `cal_done` appears 4*(t+1) cycles after the request edge.
- R2: If the comparator is still low when the code is 63, calibration ends with the code at 63 and `lim_off` high. While `lim_off` is high, no trip is ever declared.
- R3: Once calibration has finished, the calibrated code holds regardless of the comparator until the next `cal_req`.
- R4: After calibration, `dac_code` carries the calibrated code c when `ss_active` is 0. When `ss_active` is 1 it carries min(2c, 63).
- R5: After calibration, whenever the value chosen by R4 is 10 or less, `dac_code` is 0. During the ramp, `dac_code` shows the ramp count.
- R6: `pwm_hs`, `sense_cmp` and `cal_cmp` each pass through two flip-flops before any logic uses them.
- R7: A pulse that is high for N synchronised cycles yields a window of floor(3N/4) for the next pulse. N saturates at 255 (TON_W=8). The window is 0 after reset.
- R8: In normal running, with calibration done and `lim_off` low, a trip (`trip` high for one cycle) is declared when the sense comparator is high at elapsed tick j of a pulse with j < window. It is not declared when j is at or past the window.
- R9: After a trip, the current pulse completes. The next pulse may stay on for max(floor(N/2),1) ticks, where N is the length of the tripping pulse. After that, `drv_off` rises.
- R10: `drv_off` stays high for exactly 4*SS_LEN cycles. It then falls while `retry_req` is high for exactly one cycle.
- R11: From a trip until the retry, no further trip is declared.
- R12: During and just after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_req | input | 1 | Single-cycle request to start a threshold calibration |
| cal_cmp | input | 1 | Asynchronous comparator: DAC voltage has passed the set voltage |
| sense_cmp | input | 1 | Asynchronous comparator: switch sense voltage exceeds the DAC level |
| pwm_hs | input | 1 | Asynchronous high-side PWM command |
| ss_active | input | 1 | Soft-start in progress (doubles the limit) |
| dac_code | output | CODE_W | Code applied to the limit DAC |
| cal_done | output | 1 | Calibration has finished |
| lim_off | output | 1 | Ramp ran out without a comparator response; limiting disabled |
| trip | output | 1 | One-cycle overcurrent trip indication |
| drv_off | output | 1 | Both gate drivers held off |
| retry_req | output | 1 | One-cycle request to restart after the off period |

## Verification
The hardest state to reach from the ports is a trip exactly at the edge of the window. That window is set by the previous pulse, passes through two synchroniser stages, and, for long pulses, is further limited by on-time saturation. The bench handles this by sending a reference pulse first to load a known window. It then repeats the same pulse length with the sense comparator raised at tick window-1 and again at tick window, sweeping pulse lengths 2 to 12 and a 300-tick pulse that saturates. After each trip, the bench drives the next pulse and counts cycles to the gate-off edge and the retry pulse. It also toggles PWM and sense throughout the off period to show that no second trip is raised.

// File: rtl/ilim_pkg.sv
package ilim_pkg;
  typedef enum logic [1:0] {CAL_IDLE, CAL_RAMP, CAL_DONE} cal_st_e;
  typedef enum logic [1:0] {SQ_RUN, SQ_DRAIN, SQ_HALF, SQ_OFF} seq_st_e;
endpackage

// File: rtl/ilim_sync.sv
module ilim_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // R6: two flops per asynchronous input
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic s1_q, s2_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q <= 1'b0;
          s2_q <= 1'b0;
        end else begin
          s1_q <= d[g];
          s2_q <= s1_q;
        end
      end
      assign q[g] = s2_q;
    end
  endgenerate
endmodule

// File: rtl/ilim_cal.sv
module ilim_cal
  import ilim_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              cmp,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done,
  output logic              off
);
  localparam int SET_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [SET_W-1:0]  SET_LAST = SET_W'(STEP_CYC - 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  cal_st_e           st_q, st_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic [SET_W-1:0]  set_q, set_n;
  logic              off_q, off_n;

  always_comb begin
    st_n   = st_q;
    code_n = code_q;
    set_n  = set_q;
    off_n  = off_q;
    if (req) begin
      st_n   = CAL_RAMP;
      code_n = '0;
      set_n  = '0;
      off_n  = 1'b0;
    end else if (st_q == CAL_RAMP) begin
      if (set_q == SET_LAST) begin
        set_n = '0;
        if (cmp) begin
          st_n = CAL_DONE;
        end else if (code_q == CODE_MAX) begin
          st_n  = CAL_DONE;
          off_n = 1'b1;
        end else begin
          code_n = code_q + 1'b1;
        end
      end else begin
        set_n = set_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= CAL_IDLE;
      code_q <= '0;
      set_q  <= '0;
      off_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      code_q <= code_n;
      set_q  <= set_n;
      off_q  <= off_n;
    end
  end

  assign code = code_q;
  assign busy = (st_q == CAL_RAMP);
  assign done = (st_q == CAL_DONE);
  assign off  = off_q;

  assert_ramp_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_RAMP && !req) |=> (code_q == $past(code_q) || code_q == $past(code_q) + 1'b1));
  assert_hold_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CAL_DONE && !req) |=> $stable(code_q));
  assert_off_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(off_q) |-> (code_q == CODE_MAX));
endmodule

// File: rtl/ilim_ton.sv
module ilim_ton #(
  parameter int TON_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph,
  output logic             rise,
  output logic [TON_W-1:0] cnt,
  output logic [TON_W-1:0] win,
  output logic [TON_W-1:0] last
);
  localparam logic [TON_W-1:0] TON_MAX = '1;

  logic             ph_d, fall;
  logic [TON_W-1:0] cnt_q, cnt_n, win_q, win_n, last_q, last_n;
  logic [TON_W+1:0] prod;

  assign fall = ph_d && !ph;
  assign rise = ph && !ph_d;
  assign prod = {2'b00, cnt_q} + {1'b0, cnt_q, 1'b0};

  always_comb begin
    cnt_n  = ph ? ((cnt_q == TON_MAX) ? cnt_q : cnt_q + 1'b1) : '0;
    win_n  = win_q;
    last_n = last_q;
    if (fall) begin
      last_n = cnt_q;
      win_n  = prod[TON_W+1:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_d   <= 1'b0;
      cnt_q  <= '0;
      win_q  <= '0;
      last_q <= '0;
    end else begin
      ph_d   <= ph;
      cnt_q  <= cnt_n;
      win_q  <= win_n;
      last_q <= last_n;
    end
  end

  assign cnt  = cnt_q;
  assign win  = win_q;
  assign last = last_q;

  assert_window_le_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (win_q <= last_q));
endmodule

// File: rtl/ilim_seq.sv
module ilim_seq
  import ilim_pkg::*;
#(
  parameter int TON_W  = 8,
  parameter int SS_LEN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ph,
  input  logic             rise,
  input  logic             sns,
  input  logic             arm,
  input  logic [TON_W-1:0] cnt,
  input  logic [TON_W-1:0] win,
  input  logic [TON_W-1:0] last,
  output logic             trip,
  output logic             off,
  output logic             retry
);
  localparam int RETRY = 4 * SS_LEN;
  localparam int WC_W  = (RETRY > 1) ? $clog2(RETRY) : 1;
  localparam logic [WC_W-1:0] WC_LAST = WC_W'(RETRY - 1);

  seq_st_e          st_q, st_n;
  logic [WC_W-1:0]  wc_q, wc_n;
  logic             trip_q, retry_q, retry_n, trip_cond;
  logic [TON_W-1:0] half, half_eff;

  assign half      = last >> 1;
  assign half_eff  = (half == '0) ? TON_W'(1) : half;
  assign trip_cond = (st_q == SQ_RUN) && arm && ph && sns && (cnt < win);

  always_comb begin
    st_n    = st_q;
    wc_n    = wc_q;
    retry_n = 1'b0;
    unique case (st_q)
      SQ_RUN:   if (trip_cond) st_n = SQ_DRAIN;
      SQ_DRAIN: if (rise) st_n = SQ_HALF;
      SQ_HALF: begin
        if (!ph || cnt >= half_eff) begin
          st_n = SQ_OFF;
          wc_n = '0;
        end
      end
      SQ_OFF: begin
        if (wc_q == WC_LAST) begin
          st_n    = SQ_RUN;
          retry_n = 1'b1;
        end else begin
          wc_n = wc_q + 1'b1;
        end
      end
      default: st_n = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_RUN;
      wc_q    <= '0;
      trip_q  <= 1'b0;
      retry_q <= 1'b0;
    end else begin
      st_q    <= st_n;
      wc_q    <= wc_n;
      trip_q  <= trip_cond;
      retry_q <= retry_n;
    end
  end

  assign trip  = trip_q;
  assign off   = (st_q == SQ_OFF);
  assign retry = retry_q;

  assert_trip_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |-> $past(arm));
  assert_retry_after_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |-> $past(st_q == SQ_OFF));
  assert_retry_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    retry_q |=> !retry_q);
  assert_no_retrip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> !trip_q);
endmodule

// File: rtl/ilim_trip_ctrl.sv
module ilim_trip_ctrl #(
  parameter int CODE_W   = 6,
  parameter int STEP_CYC = 4,
  parameter int TON_W    = 8,
  parameter int SS_LEN   = 16,
  parameter int ZERO_MAX = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cal_req,
  input  logic              cal_cmp,
  input  logic              sense_cmp,
  input  logic              pwm_hs,
  input  logic              ss_active,
  output logic [CODE_W-1:0] dac_code,
  output logic              cal_done,
  output logic              lim_off,
  output logic              trip,
  output logic              drv_off,
  output logic              retry_req
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [CODE_W-1:0] ZERO_LIM = CODE_W'(ZERO_MAX);

  logic [2:0]        sync_q;
  logic              ph, sns, ccmp, busy, rise;
  logic [CODE_W-1:0] cal_code, eff;
  logic [CODE_W:0]   dbl;
  logic [TON_W-1:0]  cnt, win, last;

  ilim_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cal_cmp, sense_cmp, pwm_hs}), .q(sync_q)
  );
  assign ph   = sync_q[0];
  assign sns  = sync_q[1];
  assign ccmp = sync_q[2];

  ilim_cal #(.CODE_W(CODE_W), .STEP_CYC(STEP_CYC)) u_cal (
    .clk(clk), .rst_n(rst_n), .req(cal_req), .cmp(ccmp),
    .code(cal_code), .busy(busy), .done(cal_done), .off(lim_off)
  );

  ilim_ton #(.TON_W(TON_W)) u_ton (
    .clk(clk), .rst_n(rst_n), .ph(ph),
    .rise(rise), .cnt(cnt), .win(win), .last(last)
  );

  ilim_seq #(.TON_W(TON_W), .SS_LEN(SS_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .ph(ph), .rise(rise), .sns(sns),
    .arm(cal_done && !lim_off), .cnt(cnt), .win(win), .last(last),
    .trip(trip), .off(drv_off), .retry(retry_req)
  );

  // R4 doubling with clip, R5 floor to zero
  assign dbl = {cal_code, 1'b0};
  always_comb begin
    if (ss_active) eff = (dbl > {1'b0, CODE_MAX}) ? CODE_MAX : dbl[CODE_W-1:0];
    else           eff = cal_code;
    if (busy)                 dac_code = cal_code;
    else if (eff <= ZERO_LIM) dac_code = '0;
    else                      dac_code = eff;
  end
endmodule

// File: tb/sim_ilim_trip_ctrl.sv
module sim_ilim_trip_ctrl;
  localparam int RETRY = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cal_req = 1'b0, cal_cmp = 1'b0, sense_cmp = 1'b0, pwm_hs = 1'b0, ss_active = 1'b0;
  logic [5:0] dac_code;
  logic cal_done, lim_off, trip, drv_off, retry_req;
  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ilim_trip_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .cal_cmp(cal_cmp),
    .sense_cmp(sense_cmp), .pwm_hs(pwm_hs), .ss_active(ss_active),
    .dac_code(dac_code), .cal_done(cal_done), .lim_off(lim_off),
    .trip(trip), .drv_off(drv_off), .retry_req(retry_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expo(input int c, input bit ss);
    int e;
    e = ss ? ((2 * c > 63) ? 63 : 2 * c) : c;
    return (e <= 10) ? 0 : e;
  endfunction

  task automatic calib(input int t, input bit full);
    int expc, kdone;
    expc  = (t > 63) ? 63 : t;
    kdone = -1;
    @(negedge clk);
    cal_req = 1'b1;
    cal_cmp = (int'(dac_code) >= t);
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      cal_req = 1'b0;
      if (cal_done) begin kdone = k; break; end
      cal_cmp = (int'(dac_code) >= t);
    end
    if (full) begin
      chk(kdone == 1 + 4 * (expc + 1), "R1 R6 done latency", kdone, 1 + 4 * (expc + 1));
      chk(dac_code == 6'(expo(expc, 0)), "R5 code no soft-start", dac_code, expo(expc, 0));
      chk(lim_off == (t > 63), "R2 limit-off flag", lim_off, t > 63);
      ss_active = 1'b1; #1;
      chk(dac_code == 6'(expo(expc, 1)), "R4 doubled code", dac_code, expo(expc, 1));
      ss_active = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        cal_cmp = ~cal_cmp;
      end
      @(negedge clk);
      chk(dac_code == 6'(expo(expc, 0)), "R3 code held", dac_code, expo(expc, 0));
    end
    cal_cmp = 1'b0;
  endtask

  task automatic pulse(input int h, input int sa, input int sb, output int nt);
    nt = 0;
    for (int j = 0; j < h; j++) begin
      @(negedge clk);
      if (trip) nt++;
      pwm_hs = 1'b1;
      sense_cmp = (j >= sa && j <= sb);
    end
    @(negedge clk);
    if (trip) nt++;
    pwm_hs = 1'b0;
    sense_cmp = 1'b0;
    for (int j = 0; j < 12; j++) begin
      @(negedge clk);
      if (trip) nt++;
    end
  endtask

  task automatic recover(input int m);
    int cnt, nt;
    bit got;
    cnt = 1; nt = 0; got = 0;
    @(negedge clk);
    pwm_hs = 1'b1;
    for (int i = 1; i <= m + 3; i++) begin
      @(negedge clk);
      if (i == m + 2) chk(drv_off == 1'b0, "R9 on before half point", drv_off, 0);
      if (i == m + 3) chk(drv_off == 1'b1, "R9 off after half point", drv_off, 1);
    end
    pwm_hs = 1'b0;
    for (int k = 0; k < RETRY + 8; k++) begin
      @(negedge clk);
      if (trip) nt++;
      if (drv_off) cnt++;
      else begin got = retry_req; break; end
      if (k < RETRY - 12) begin
        pwm_hs = ((k % 8) < 4);
        sense_cmp = pwm_hs;
      end else begin
        pwm_hs = 1'b0;
        sense_cmp = 1'b0;
      end
    end
    chk(cnt == RETRY, "R10 off duration", cnt, RETRY);
    chk(got == 1'b1, "R10 retry pulse", got, 1);
    chk(nt == 0, "R11 no trip while off", nt, 0);
    @(negedge clk);
    chk(retry_req == 1'b0, "R10 retry one cycle", retry_req, 0);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    int nt, w;
    repeat (3) @(negedge clk);
    chk({dac_code, cal_done, lim_off, trip, drv_off, retry_req} == '0, "R12 in reset", dac_code, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dac_code, cal_done, lim_off, trip, drv_off, retry_req} == '0, "R12 after reset", dac_code, 0);

    calib(20, 1);
    pulse(40, 0, 0, nt);
    chk(nt == 0, "R7 zero window after reset", nt, 0);

    for (int t = 0; t <= 64; t++) calib(t, 1);

    pulse(40, -1, -2, nt);
    pulse(40, 0, 39, nt);
    chk(nt == 0, "R2 no trip when limit off", nt, 0);

    calib(20, 0);
    pulse(40, -1, -2, nt);
    pulse(40, 30, 30, nt);
    chk(nt == 0, "R8 sense at window edge", nt, 0);
    pulse(40, 29, 39, nt);
    chk(nt == 1, "R8 R11 single trip inside window", nt, 1);
    recover(20);

    for (int h = 2; h <= 12; h++) begin
      w = (3 * h) / 4;
      pulse(h, -1, -2, nt);
      pulse(h, w, w, nt);
      chk(nt == 0, "R8 sense at window", nt, 0);
      pulse(h, w - 1, w - 1, nt);
      chk(nt == 1, "R7 R8 sense at window-1", nt, 1);
      recover((h / 2 > 1) ? h / 2 : 1);
    end

    pulse(300, -1, -2, nt);
    pulse(300, 191, 191, nt);
    chk(nt == 0, "R7 saturated window edge", nt, 0);
    pulse(300, 190, 190, nt);
    chk(nt == 1, "R7 saturated window inside", nt, 1);
    recover(127);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule